// File: doc/BRIEF.md
# LCD Output Edge and Polarity Stage

This stage sits between a raster timing source and an LCD panel. It produces the pixel clock itself from a system clock that runs at twice the pixel rate. Because of that, it can register any of its outputs in the system-clock cycle that makes the pixel clock rise, or in the cycle that makes it fall. Pixel data together with the data-enable (ac-bias) signal is launched on one selectable pixel-clock edge. Horizontal and vertical sync are launched on an edge that is either tied to the data edge or chosen on its own.

The configuration has five bits. They cover inversion of the data launch edge, choice of the sync edge, whether the sync edge follows the data edge or is set on its own, the data-enable polarity, and active versus passive display mode. These bits are captured only when the vertical sync input rises, so one frame never mixes two edge settings. The timing source holds every input stable for a whole pixel period. The stage registers each input once, at the transition that belongs to that output.

Top module: `lcd_edge_out`

## Requirements
- R1: While `rst` is high at a clock edge, every output is driven to 0 after that edge, including `pclk_o`. The latched configuration returns to all zeros, which is the default setting.
- R2: After reset is released, `pclk_o` inverts on every system-clock edge. The first edge after reset drives it high.
- R3: With the latched invert bit at 0 and sync select at 0, `pix_o` and `de_o` change only at the edge that drives `pclk_o` high. `hs_o` and `vs_o` change only at the edge that drives `pclk_o` low.
- R4: With the latched invert bit at 1 and sync select at 0, `pix_o` and `de_o` are launched at the edge that drives `pclk_o` low. `hs_o` and `vs_o` are launched at the edge that drives it high.
- R5: With the latched sync select at 1, the latched sync-edge bit alone picks the sync launch edge: 0 means `pclk_o` rising and 1 means `pclk_o` falling. The invert bit has no influence on the sync edge.
- R6: In active mode (`cfg_active` = 1), `de_o` is loaded with `de_in` XOR `cfg_de_low`. A polarity bit of 1 therefore gives an active-low enable, and 0 gives an active-high one.
- R7: In passive mode (`cfg_active` = 0), `de_o` is loaded with `de_in` unchanged, whatever the polarity bit is.
- R8: The configuration inputs are latched at a clock edge only when `vs_in` is 1 at that edge and was 0 at the previous edge. The launch decisions taken at that same edge still use the previous setting. Changes to the configuration inputs at any other time have no effect on the outputs.
- R9: At its launch edge, each output register takes the value its input has at that clock edge. Between its launch edges, it holds that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pclk_inv | input | 1 | 1 launches data on the falling pixel-clock edge |
| cfg_sync_edge | input | 1 | Sync edge when sync select is 1 (0 rising, 1 falling) |
| cfg_sync_sel | input | 1 | 1 lets cfg_sync_edge choose the sync edge |
| cfg_de_low | input | 1 | Data-enable polarity in active mode (1 active low) |
| cfg_active | input | 1 | 1 active display mode, 0 passive |
| pix_in | input | DATA_W | Pixel data from the timing source |
| hs_in | input | 1 | Horizontal sync from the timing source |
| vs_in | input | 1 | Vertical sync from the timing source; its rise latches the configuration |
| de_in | input | 1 | Data-enable from the timing source, active high |
| pclk_o | output | 1 | Generated pixel clock |
| pix_o | output | DATA_W | Launched pixel data |
| hs_o | output | 1 | Launched horizontal sync |
| vs_o | output | 1 | Launched vertical sync |
| de_o | output | 1 | Launched data-enable (ac-bias) |

## Verification
The hardest case to reach is a configuration change that must not take effect: the setting inputs move while a frame is running, and the launch edges must still follow the setting captured at the last vertical-sync rise. The bench sweeps all 32 setting words. For each one it makes a vertical-sync rise to capture the word, then drives changing data and sync patterns. After that it inverts every configuration input without a new rise and keeps comparing against the old setting. Its model updates the expected outputs at each clock edge from the requirements. Each output is compared half a period later.

// File: rtl/lcdo_pkg.sv
package lcdo_pkg;
  typedef struct packed {
    logic pclk_inv;   // data launched on falling edge
    logic sync_edge;  // 0 rise, 1 fall when sync_sel
    logic sync_sel;   // sync edge chosen independently
    logic de_low;     // active-low enable in active mode
    logic active;     // active display mode
  } lcdo_cfg_t;

  localparam lcdo_cfg_t CFG_DEFAULT = '0;
endpackage

// File: rtl/lcdo_cfg_latch.sv
module lcdo_cfg_latch
  import lcdo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       vs_in,
  input  lcdo_cfg_t  cfg_in,
  output lcdo_cfg_t  cfg_q,
  output logic       vs_prev
);
  logic frame_start;
  assign frame_start = vs_in & ~vs_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= CFG_DEFAULT;
      vs_prev <= 1'b0;
    end else begin
      vs_prev <= vs_in;
      if (frame_start) cfg_q <= cfg_in;
    end
  end
endmodule

// File: rtl/lcdo_edge_gen.sv
module lcdo_edge_gen
  import lcdo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  lcdo_cfg_t  cfg,
  output logic       pclk_q,
  output logic       data_go,
  output logic       sync_go
);
  logic rise_next;
  logic sync_fall;

  // the update in this cycle drives the pixel clock high
  assign rise_next = ~pclk_q;
  assign sync_fall = cfg.sync_sel ? cfg.sync_edge : ~cfg.pclk_inv;
  assign data_go   = cfg.pclk_inv ? ~rise_next : rise_next;
  assign sync_go   = sync_fall    ? ~rise_next : rise_next;

  always_ff @(posedge clk) begin
    if (rst) pclk_q <= 1'b0;
    else     pclk_q <= ~pclk_q;
  end
endmodule

// File: rtl/lcdo_launch_reg.sv
module lcdo_launch_reg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/lcd_edge_out.sv
module lcd_edge_out
  import lcdo_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_pclk_inv,
  input  logic              cfg_sync_edge,
  input  logic              cfg_sync_sel,
  input  logic              cfg_de_low,
  input  logic              cfg_active,
  input  logic [DATA_W-1:0] pix_in,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic              de_in,
  output logic              pclk_o,
  output logic [DATA_W-1:0] pix_o,
  output logic              hs_o,
  output logic              vs_o,
  output logic              de_o
);
  localparam int DLANE_W = DATA_W + 1;  // pixel bus plus enable
  localparam int SLANE_W = 2;           // hsync and vsync

  lcdo_cfg_t cfg_in, cfg_q;
  logic      vs_prev;
  logic      data_go, sync_go;
  logic      de_val;

  assign cfg_in = '{pclk_inv: cfg_pclk_inv, sync_edge: cfg_sync_edge,
                    sync_sel: cfg_sync_sel, de_low: cfg_de_low,
                    active: cfg_active};

  lcdo_cfg_latch u_cfg (
    .clk(clk), .rst(rst), .vs_in(vs_in), .cfg_in(cfg_in),
    .cfg_q(cfg_q), .vs_prev(vs_prev)
  );

  lcdo_edge_gen u_edge (
    .clk(clk), .rst(rst), .cfg(cfg_q),
    .pclk_q(pclk_o), .data_go(data_go), .sync_go(sync_go)
  );

  // polarity applies in active mode only
  assign de_val = cfg_q.active ? (de_in ^ cfg_q.de_low) : de_in;

  logic [DLANE_W-1:0] dlane_q;
  logic [SLANE_W-1:0] slane_q;

  lcdo_launch_reg #(.W(DLANE_W)) u_dlane (
    .clk(clk), .rst(rst), .en(data_go),
    .d({de_val, pix_in}), .q(dlane_q)
  );

  lcdo_launch_reg #(.W(SLANE_W)) u_slane (
    .clk(clk), .rst(rst), .en(sync_go),
    .d({vs_in, hs_in}), .q(slane_q)
  );

  assign pix_o = dlane_q[DATA_W-1:0];
  assign de_o  = dlane_q[DATA_W];
  assign hs_o  = slane_q[0];
  assign vs_o  = slane_q[1];
endmodule

// File: rtl/lcd_edge_out_chk.sv
module lcd_edge_out_chk
  import lcdo_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              pclk_o,
  input logic [DATA_W-1:0] pix_o,
  input logic              hs_o,
  input logic              vs_o,
  input logic              de_o,
  input logic              de_in,
  input logic              vs_in,
  input logic              vs_prev,
  input lcdo_cfg_t         cfg_q
);
  logic up_q;
  always_ff @(posedge clk) begin
    if (rst) up_q <= 1'b0;
    else     up_q <= 1'b1;
  end

  logic sfall;
  assign sfall = cfg_q.sync_sel ? cfg_q.sync_edge : ~cfg_q.pclk_inv;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!pclk_o && pix_o == '0 && !hs_o && !vs_o && !de_o)); // R1

  AST_PCLK_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    up_q |-> (pclk_o != $past(pclk_o))); // R2

  AST_DATA_EDGE: assert property (@(posedge clk) disable iff (rst)
    (up_q && pix_o != $past(pix_o)) |-> (pclk_o == !$past(cfg_q.pclk_inv))); // R3

  AST_SYNC_EDGE: assert property (@(posedge clk) disable iff (rst)
    (up_q && (hs_o != $past(hs_o) || vs_o != $past(vs_o)))
      |-> (pclk_o == !$past(sfall))); // R5

  AST_DE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (up_q && $past(cfg_q.active) && de_o != $past(de_o))
      |-> (de_o == ($past(de_in) ^ $past(cfg_q.de_low)))); // R6

  AST_DE_PASSIVE: assert property (@(posedge clk) disable iff (rst)
    (up_q && !$past(cfg_q.active) && de_o != $past(de_o))
      |-> (de_o == $past(de_in))); // R7

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (up_q && !$past(vs_in && !vs_prev)) |-> $stable(cfg_q)); // R8
endmodule

bind lcd_edge_out lcd_edge_out_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .pclk_o(pclk_o), .pix_o(pix_o), .hs_o(hs_o),
  .vs_o(vs_o), .de_o(de_o), .de_in(de_in), .vs_in(vs_in),
  .vs_prev(vs_prev), .cfg_q(cfg_q)
);

// File: tb/lcd_edge_out_bench.sv
`timescale 1ns/1ps
module lcd_edge_out_bench;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [4:0]    cfg = '0;  // {active, de_low, sync_sel, sync_edge, pclk_inv}
  logic [DW-1:0] pix_in = '0;
  logic          hs_in = 1'b0, vs_in = 1'b0, de_in = 1'b0;
  logic          pclk_o, hs_o, vs_o, de_o;
  logic [DW-1:0] pix_o;

  int n_chk = 0, n_bad = 0;
  bit r8_phase = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  lcd_edge_out #(.DATA_W(DW)) u_lcd_edge_out (
    .clk(clk), .rst(rst),
    .cfg_pclk_inv(cfg[0]), .cfg_sync_edge(cfg[1]), .cfg_sync_sel(cfg[2]),
    .cfg_de_low(cfg[3]), .cfg_active(cfg[4]),
    .pix_in(pix_in), .hs_in(hs_in), .vs_in(vs_in), .de_in(de_in),
    .pclk_o(pclk_o), .pix_o(pix_o), .hs_o(hs_o), .vs_o(vs_o), .de_o(de_o)
  );

  // requirement-level model, updated at each clock edge
  logic          m_pclk = 0, m_hs = 0, m_vs = 0, m_de = 0, m_vsp = 0;
  logic [DW-1:0] m_pix = '0;
  logic [4:0]    m_cfg = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_pclk = 0; m_pix = '0; m_hs = 0; m_vs = 0; m_de = 0;
      m_cfg = '0; m_vsp = 0;
    end else begin
      logic rise, dgo, sfall, sgo;
      rise  = !m_pclk;
      dgo   = m_cfg[0] ? !rise : rise;                 // R3 R4
      sfall = m_cfg[2] ? m_cfg[1] : !m_cfg[0];         // R5
      sgo   = sfall ? !rise : rise;
      if (dgo) begin
        m_pix = pix_in;                                // R9
        m_de  = m_cfg[4] ? (de_in ^ m_cfg[3]) : de_in; // R6 R7
      end
      if (sgo) begin m_hs = hs_in; m_vs = vs_in; end
      m_pclk = !m_pclk;                                // R2
      if (vs_in && !m_vsp) m_cfg = cfg;                // R8
      m_vsp = vs_in;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string td, ts, tde;
    if (r8_phase) begin td = "R8"; ts = "R8"; tde = "R8"; end
    else begin
      td  = m_cfg[0] ? "R4/R9" : "R3/R9";
      ts  = m_cfg[2] ? "R5" : (m_cfg[0] ? "R4" : "R3");
      tde = m_cfg[4] ? "R6" : "R7";
    end
    chk("R2 pclk", {31'b0, pclk_o}, {31'b0, m_pclk});
    chk({td, " pix"}, {{(32-DW){1'b0}}, pix_o}, {{(32-DW){1'b0}}, m_pix});
    chk({ts, " hs"}, {31'b0, hs_o}, {31'b0, m_hs});
    chk({ts, " vs"}, {31'b0, vs_o}, {31'b0, m_vs});
    chk({tde, " de"}, {31'b0, de_o}, {31'b0, m_de});
  endtask

  // one cycle: compare at the falling edge, then drive new inputs
  task automatic step(input int k);
    @(negedge clk);
    compare_all();
    pix_in = DW'((k * 37) ^ (k >> 2));
    hs_in  = k[1] ^ k[3];
    de_in  = k[0] ^ k[2];
  endtask

  initial begin
    // reset: R1
    repeat (3) begin
      @(negedge clk);
      chk("R1 pclk", {31'b0, pclk_o}, 32'd0);
      chk("R1 pix", {{(32-DW){1'b0}}, pix_o}, 32'd0);
      chk("R1 sync", {30'b0, hs_o, vs_o}, 32'd0);
      chk("R1 de", {31'b0, de_o}, 32'd0);
    end
    rst = 1'b0;
    // default setting, no frame start yet (R3)
    for (int k = 0; k < 12; k++) step(k);
    for (int c = 0; c < 32; c++) begin
      r8_phase = 1'b0;
      cfg = 5'(c);
      vs_in = 1'b0;
      for (int k = 0; k < 3; k++) step(k + c);
      vs_in = 1'b1;   // frame start latches cfg
      for (int k = 0; k < 3; k++) step(k + 3 * c);
      vs_in = 1'b0;
      for (int k = 0; k < 20; k++) step(k * 5 + c);
      // R8: setting moves with no frame start
      @(negedge clk);
      cfg = ~5'(c);
      r8_phase = 1'b1;
      for (int k = 0; k < 10; k++) step(k * 3 + c);
    end
    r8_phase = 1'b0;
    // re-enter reset mid-run: R1
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 pclk", {31'b0, pclk_o}, 32'd0);
    chk("R1 outs", {{(32-DW){1'b0}}, pix_o} | {28'b0, hs_o, vs_o, de_o, 1'b0}, 32'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule